// File: doc/BRIEF.md
# Return Stack with Shadow Restore

This block is the return-address side of a small 8-bit microcontroller core. Call sites push a full program counter value onto a hardware last-in first-out store. When the core presents the subroutine-return instruction word, the block pops the newest entry into its program counter register. Bit 0 of that word selects a fast return: the working register (W), the status register and the bank-select register are then reloaded, in the same clock edge, from three shadow copies.

A return is one instruction word and occupies two instruction cycles. In the first cycle the block decodes the word, pops the stack and updates the program counter. The second cycle is a dead slot: the block reports itself busy and ignores any instruction word presented. A two-state machine sequences this. `ST_READY` accepts instructions. `ST_SLOT` is the dead slot. The transition READY→SLOT is taken on an accepted return. SLOT→READY is taken unconditionally on the next edge. In every other case READY→READY holds.

The live W, status and bank registers can be loaded from the core through a write strobe. A capture strobe copies all three live registers into the shadows at once, which stands in for the capture the core makes on interrupt or call. The stack has a parameterised depth. Popping an empty stack and pushing onto a full stack each set a sticky error flag, and the stack pointer saturates instead of wrapping.

Top module: `retstack_ctrl`

## Requirements
- R1: After reset, `pc_q`, `w_q`, `status_q`, `bsr_q`, all three shadow outputs, `underflow`, `overflow` and `busy` are all zero, and the stack is empty.
- R2: A return is recognised only when `instr_valid` is 1, the block is not busy, and `instr_word[15:1]` equals 15'h0009 (words 16'h0012 and 16'h0013). Any other word changes neither `pc_q` nor W, status or bank.
- R3: An accepted return loads `pc_q`, at the same clock edge, with the most recently pushed entry that has not yet been popped. Entries come back in last-in first-out order. `pc_q` changes on no other event.
- R4: On the edge that accepts a return, `busy` rises for exactly one cycle. An instruction word presented while `busy` is 1 has no effect.
- R5: When `instr_word[0]` is 1 on an accepted return, `w_q`, `status_q` and `bsr_q` take the values of `shadow_w`, `shadow_status` and `shadow_bsr` at that edge. This restore takes precedence over a `core_wr` in the same cycle.
- R6: When `instr_word[0]` is 0 on an accepted return, `w_q`, `status_q` and `bsr_q` keep their values. No status flag is altered.
- R7: `shadow_cap` copies `w_q`, `status_q` and `bsr_q` into the three shadows together, at the next edge. `core_wr` loads the three live registers from `core_w`, `core_status` and `core_bsr`.
- R8: `push_en` stores `push_addr` as the new top entry. A push in the same cycle as an accepted return is dropped.
- R9: A return accepted while the stack is empty sets `underflow`, which stays 1 until reset. `pc_q` stays unchanged and the pointer stays at empty.
- R10: A push while DEPTH entries are held sets `overflow`, which stays 1 until reset. The pushed value is discarded and the existing entries remain intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr_word | input | 16 | Instruction word |
| push_en | input | 1 | Push a return address (call) |
| push_addr | input | PC_W | Address to push |
| core_wr | input | 1 | Load W, status and bank from the core |
| core_w | input | DATA_W | New W value |
| core_status | input | DATA_W | New status value |
| core_bsr | input | BANK_W | New bank-select value |
| shadow_cap | input | 1 | Copy live registers into the shadows |
| pc_q | output | PC_W | Program counter |
| w_q | output | DATA_W | Working register |
| status_q | output | DATA_W | Status register |
| bsr_q | output | BANK_W | Bank-select register |
| shadow_w | output | DATA_W | W shadow |
| shadow_status | output | DATA_W | Status shadow |
| shadow_bsr | output | BANK_W | Bank-select shadow |
| busy | output | 1 | Return dead slot in progress |
| underflow | output | 1 | Sticky: pop from empty stack |
| overflow | output | 1 | Sticky: push onto full stack |

## Verification
A corrupted stack pointer or entry shows up on `pc_q` at the very next accepted return, one edge after the instruction word is presented. The bench therefore pops every scenario's entries and compares the full last-in first-out sequence. A stuck or skipped FSM state shows within one cycle: either `busy` fails to rise or fall on schedule, or a word presented during the slot changes `pc_q`. A wrong restore path or shadow capture shows up on `w_q`, `status_q` or `bsr_q` on the edge of the fast return.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
    // Sequencer states for the two-cycle return
    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_SLOT  = 1'b1
    } rs_state_e;

    // Upper fifteen bits of the return word; bit 0 is the fast-restore select
    localparam logic [14:0] RET_OPC_HI = 15'h0009;
endpackage

// File: rtl/retstack_decode.sv
module retstack_decode
    import retstack_pkg::*;
(
    input  logic [15:0] word,
    output logic        is_ret,
    output logic        fast
);
    always_comb begin
        is_ret = (word[15:1] == RET_OPC_HI);
        fast   = word[0];
    end
endmodule

// File: rtl/retstack_lifo.sv
module retstack_lifo #(
    parameter int DEPTH = 31,
    parameter int AW    = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] top_data,
    output logic          empty,
    output logic          ovf,
    output logic          unf
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] ptr;
    logic          full;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    always_comb begin
        empty    = (ptr == '0);
        full     = (ptr == PW'(DEPTH));
        wr_idx   = IW'(ptr);
        rd_idx   = IW'(ptr - PW'(1));
        top_data = empty ? '0 : mem[rd_idx];
    end

    // storage array: written only on an accepted push
    always_ff @(posedge clk) begin
        if (push && !pop && !full) begin
            mem[wr_idx] <= push_data;
        end
    end

    // pointer and sticky error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (pop) begin
                if (empty) unf <= 1'b1;
                else       ptr <= ptr - PW'(1);
            end else if (push) begin
                if (full) ovf <= 1'b1;
                else      ptr <= ptr + PW'(1);
            end
        end
    end
endmodule

// File: rtl/retstack_shadow.sv
module retstack_shadow #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_w,
    input  logic [DATA_W-1:0] wr_status,
    input  logic [BANK_W-1:0] wr_bsr,
    input  logic              cap,
    input  logic              restore,
    output logic [DATA_W-1:0] w_q,
    output logic [DATA_W-1:0] status_q,
    output logic [BANK_W-1:0] bsr_q,
    output logic [DATA_W-1:0] sh_w,
    output logic [DATA_W-1:0] sh_status,
    output logic [BANK_W-1:0] sh_bsr
);
    // live registers: restore outranks a core write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q      <= '0;
            status_q <= '0;
            bsr_q    <= '0;
        end else if (restore) begin
            w_q      <= sh_w;
            status_q <= sh_status;
            bsr_q    <= sh_bsr;
        end else if (wr) begin
            w_q      <= wr_w;
            status_q <= wr_status;
            bsr_q    <= wr_bsr;
        end
    end

    // shadow copies, loaded together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_w      <= '0;
            sh_status <= '0;
            sh_bsr    <= '0;
        end else if (cap) begin
            sh_w      <= w_q;
            sh_status <= status_q;
            sh_bsr    <= bsr_q;
        end
    end
endmodule

// File: rtl/retstack_ctrl.sv
module retstack_ctrl
    import retstack_pkg::*;
#(
    parameter int DEPTH  = 31,
    parameter int PC_W   = 21,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic              push_en,
    input  logic [PC_W-1:0]   push_addr,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_w,
    input  logic [DATA_W-1:0] core_status,
    input  logic [BANK_W-1:0] core_bsr,
    input  logic              shadow_cap,
    output logic [PC_W-1:0]   pc_q,
    output logic [DATA_W-1:0] w_q,
    output logic [DATA_W-1:0] status_q,
    output logic [BANK_W-1:0] bsr_q,
    output logic [DATA_W-1:0] shadow_w,
    output logic [DATA_W-1:0] shadow_status,
    output logic [BANK_W-1:0] shadow_bsr,
    output logic              busy,
    output logic              underflow,
    output logic              overflow
);
    rs_state_e state_q, state_d;

    logic            dec_ret, dec_fast;
    logic            accept, do_pop, do_push, do_restore;
    logic [PC_W-1:0] tos;
    logic            stk_empty;

    retstack_decode u_dec (
        .word   (instr_word),
        .is_ret (dec_ret),
        .fast   (dec_fast)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            ST_READY: begin
                accept = instr_valid && dec_ret;
                if (accept) state_d = ST_SLOT;
            end
            ST_SLOT: begin
                busy    = 1'b1;
                state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
        do_pop     = accept;
        do_restore = accept && dec_fast;
        do_push    = push_en && !accept;
    end

    retstack_lifo #(.DEPTH(DEPTH), .AW(PC_W)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_data (push_addr),
        .pop       (do_pop),
        .top_data  (tos),
        .empty     (stk_empty),
        .ovf       (overflow),
        .unf       (underflow)
    );

    retstack_shadow #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_shd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (core_wr),
        .wr_w      (core_w),
        .wr_status (core_status),
        .wr_bsr    (core_bsr),
        .cap       (shadow_cap),
        .restore   (do_restore),
        .w_q       (w_q),
        .status_q  (status_q),
        .bsr_q     (bsr_q),
        .sh_w      (shadow_w),
        .sh_status (shadow_status),
        .sh_bsr    (shadow_bsr)
    );

    // program counter: loaded only by a non-empty pop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pc_q <= '0;
        else if (do_pop && !stk_empty) pc_q <= tos;
    end
endmodule

// File: rtl/retstack_chk.sv
module retstack_chk #(
    parameter int PC_W   = 21,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [15:0]       instr_word,
    input logic              core_wr,
    input logic              shadow_cap,
    input logic [PC_W-1:0]   pc_q,
    input logic [DATA_W-1:0] w_q,
    input logic [DATA_W-1:0] status_q,
    input logic [BANK_W-1:0] bsr_q,
    input logic [DATA_W-1:0] shadow_w,
    input logic [DATA_W-1:0] shadow_status,
    input logic [BANK_W-1:0] shadow_bsr,
    input logic              busy,
    input logic              underflow,
    input logic              overflow
);
    logic acc;
    assign acc = instr_valid && !busy && (instr_word[15:1] == 15'h0009);

    // R4
    ret_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);
    // R4
    slot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(pc_q));
    // R5
    fast_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && instr_word[0]) |=> (w_q == $past(shadow_w)) &&
            (status_q == $past(shadow_status)) && (bsr_q == $past(shadow_bsr)));
    // R6
    keep_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !instr_word[0] && !core_wr) |=>
            ($stable(w_q) && $stable(status_q) && $stable(bsr_q)));
    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_cap |=> (shadow_w == $past(w_q)) &&
            (shadow_status == $past(status_q)) && (shadow_bsr == $past(bsr_q)));
    // R9
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind retstack_ctrl retstack_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_word    (instr_word),
    .core_wr       (core_wr),
    .shadow_cap    (shadow_cap),
    .pc_q          (pc_q),
    .w_q           (w_q),
    .status_q      (status_q),
    .bsr_q         (bsr_q),
    .shadow_w      (shadow_w),
    .shadow_status (shadow_status),
    .shadow_bsr    (shadow_bsr),
    .busy          (busy),
    .underflow     (underflow),
    .overflow      (overflow)
);

// File: tb/retstack_ctrl_test.sv
`timescale 1ns/1ps
module retstack_ctrl_test;
    localparam int DEPTH = 31;
    localparam int PC_W  = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        push_en = 1'b0;
    logic [20:0] push_addr = '0;
    logic        core_wr = 1'b0;
    logic [7:0]  core_w = '0, core_status = '0;
    logic [3:0]  core_bsr = '0;
    logic        shadow_cap = 1'b0;
    logic [20:0] pc_q;
    logic [7:0]  w_q, status_q, shadow_w, shadow_status;
    logic [3:0]  bsr_q, shadow_bsr;
    logic        busy, underflow, overflow;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    retstack_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .push_en(push_en), .push_addr(push_addr), .core_wr(core_wr), .core_w(core_w),
        .core_status(core_status), .core_bsr(core_bsr), .shadow_cap(shadow_cap),
        .pc_q(pc_q), .w_q(w_q), .status_q(status_q), .bsr_q(bsr_q),
        .shadow_w(shadow_w), .shadow_status(shadow_status), .shadow_bsr(shadow_bsr),
        .busy(busy), .underflow(underflow), .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        instr_valid = 1'b0; push_en = 1'b0; core_wr = 1'b0; shadow_cap = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic push(input logic [20:0] a);
        push_en = 1'b1; push_addr = a;
        tick();
        push_en = 1'b0;
    endtask

    // issue a return; after this, the slot cycle is current
    task automatic ret(input logic s);
        instr_valid = 1'b1; instr_word = {15'h0009, s};
        tick();
        instr_valid = 1'b0;
    endtask

    task automatic load_regs(input logic [7:0] w, input logic [7:0] st, input logic [3:0] b);
        core_wr = 1'b1; core_w = w; core_status = st; core_bsr = b;
        tick();
        core_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pc", 32'(pc_q), 0);
        check("R1 regs", {8'h0, w_q, status_q, 4'h0, bsr_q}, 0);
        check("R1 shadows", {8'h0, shadow_w, shadow_status, 4'h0, shadow_bsr}, 0);
        check("R1 flags", {29'h0, busy, underflow, overflow}, 0);
    endtask

    task automatic t_lifo_order();
        do_reset();
        push(21'h1_2345); push(21'h0_0ABC); push(21'h1F_FFFF);
        ret(1'b0);
        check("R3 first pop", 32'(pc_q), 32'h1F_FFFF);
        check("R4 busy in slot", 32'(busy), 1);
        tick();
        check("R4 busy cleared", 32'(busy), 0);
        ret(1'b0); tick();
        check("R3 second pop", 32'(pc_q), 32'h0_0ABC);
        ret(1'b0); tick();
        check("R3 third pop", 32'(pc_q), 32'h1_2345);
        check("R9 no underflow yet", 32'(underflow), 0);
    endtask

    task automatic t_slot_ignore();
        do_reset();
        push(21'h111); push(21'h222);
        instr_valid = 1'b1; instr_word = 16'h0012;
        tick();   // accepted
        tick();   // slot: word still presented, must be ignored
        instr_valid = 1'b0;
        check("R4 slot word ignored pc", 32'(pc_q), 32'h222);
        ret(1'b0); tick();
        check("R4 slot pop not taken", 32'(pc_q), 32'h111);
    endtask

    task automatic t_nonret();
        do_reset();
        push(21'h555);
        load_regs(8'hA1, 8'h1F, 4'h3);
        shadow_cap = 1'b1; tick(); shadow_cap = 1'b0;
        load_regs(8'h00, 8'h00, 4'h0);
        instr_valid = 1'b1; instr_word = 16'h0011; tick();
        instr_word = 16'h0015; tick();
        instr_word = 16'h8013; tick();
        instr_valid = 1'b0;
        check("R2 other words pc", 32'(pc_q), 0);
        check("R2 other words regs", {w_q, status_q, bsr_q}, 0);
        check("R2 other words busy", 32'(busy), 0);
        ret(1'b0);
        check("R2 0x0012 accepted", 32'(pc_q), 32'h555);
        tick();
    endtask

    task automatic t_fast_and_plain();
        do_reset();
        push(21'hAAA); push(21'hBBB);
        load_regs(8'h5A, 8'h1C, 4'hE);
        shadow_cap = 1'b1; tick(); shadow_cap = 1'b0;
        check("R7 capture", {shadow_w, shadow_status, 4'h0, shadow_bsr}, 32'h5A1C0E);
        load_regs(8'h33, 8'h07, 4'h2);
        check("R7 core write", {w_q, status_q, 4'h0, bsr_q}, 32'h33070_2);
        ret(1'b0);
        check("R6 plain keeps regs", {w_q, status_q, 4'h0, bsr_q}, 32'h330702);
        tick();
        // fast return with a competing core write: restore wins
        core_wr = 1'b1; core_w = 8'hFF; core_status = 8'hFF; core_bsr = 4'hF;
        ret(1'b1);
        core_wr = 1'b0;
        check("R5 fast restore", {w_q, status_q, 4'h0, bsr_q}, 32'h5A1C0E);
        check("R5 fast pc", 32'(pc_q), 32'hAAA);
        tick();
    endtask

    task automatic t_push_collide();
        do_reset();
        push(21'h10); push(21'h20);
        push_en = 1'b1; push_addr = 21'h99;
        ret(1'b0);
        push_en = 1'b0;
        check("R8 pop during push", 32'(pc_q), 32'h20);
        tick();
        ret(1'b0); tick();
        check("R8 colliding push dropped", 32'(pc_q), 32'h10);
        check("R8 stack now empty ok", 32'(underflow), 0);
    endtask

    task automatic t_underflow();
        do_reset();
        push(21'h77); ret(1'b0); tick();
        ret(1'b0); tick();
        check("R9 underflow set", 32'(underflow), 1);
        check("R9 pc unchanged", 32'(pc_q), 32'h77);
        push(21'h44);
        ret(1'b0); tick();
        check("R9 pointer held at empty", 32'(pc_q), 32'h44);
        check("R9 sticky", 32'(underflow), 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(21'(i + 1));
        check("R10 full no flag", 32'(overflow), 0);
        push(21'h1ABCD);
        check("R10 overflow set", 32'(overflow), 1);
        ret(1'b0); tick();
        check("R10 top intact", 32'(pc_q), 32'(DEPTH));
        for (int i = DEPTH - 1; i >= 1; i--) begin
            ret(1'b0); tick();
        end
        check("R10 bottom intact", 32'(pc_q), 1);
        check("R10 sticky", 32'(overflow), 1);
        check("R10 no underflow", 32'(underflow), 0);
    endtask

    initial begin
        #1;
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_lifo_order();
        t_slot_ignore();
        t_nonret();
        t_fast_and_plain();
        t_push_collide();
        t_underflow();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule